// File: doc/BRIEF.md
# Configurable Four-Mode GPIO Port

This block is an eight-pin general-purpose I/O port. Each pin chooses one of four drive styles through a two-bit mode field: quasi-bidirectional, input-only, push-pull or open-drain. The block does not drive the pads itself. For each pin it produces three enables that an external pad model turns into the real pin: a strong high, a weak pull-up and a strong low. It takes the raw pad levels back in and passes each one through a digital glitch filter before the level can be read.

Software reaches the block through a small register window:

- Two configuration registers hold the mode fields, one for the lower four pins and one for the upper four.
- A level register has two meanings. A write sets the output latch of the pins that are outputs. A read returns the filtered level of all eight pins.

In quasi-bidirectional mode, a latch transition from 0 to 1 adds a strong pull-up for two clocks, so the pin line charges quickly before the weak pull-up holds it.

Each pin has a boost state machine with three states:

- `BST_IDLE` is the state with no boost.
- `BST_FIRST` is the first boost clock.
- `BST_SECOND` is the second boost clock.

Its transitions are:

- rise-start: any state goes to `BST_FIRST` when a write raises the latch from 0 to 1.
- boost-advance: `BST_FIRST` goes to `BST_SECOND`.
- boost-end: `BST_SECOND` goes to `BST_IDLE`.
- idle-hold: `BST_IDLE` stays in `BST_IDLE`.

Each pin's filter has two states:

- `F_STEADY` means no change is pending.
- `F_CONFIRM` means the pad differs from the accepted level and is being counted.

Its transitions are:

- change-seen: `F_STEADY` goes to `F_CONFIRM`.
- change-dropped: `F_CONFIRM` goes back to `F_STEADY` when the pad returns to the accepted level.
- change-accepted: `F_CONFIRM` goes to `F_STEADY` and updates the accepted level once the count completes.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset, both configuration registers read 0x55, so every pin is input-only. The output latch holds 0x0F, with pins 3..0 at 1 and pins 7..4 at 0.
- R2: `wr_sel`/`rd_sel` code 0 selects the configuration register for pins 3..0, code 1 selects the one for pins 7..4, and code 2 selects the level register. Pin n uses bits [2k+1:2k] of its configuration register, with k = n mod 4. The mode codes are 00 quasi-bidirectional, 01 input-only, 10 push-pull and 11 open-drain.
- R3: In push-pull mode, latch 1 asserts only `pad_drv_hi` and latch 0 asserts only `pad_drv_lo`.
- R4: In open-drain mode, only `pad_drv_lo` can be asserted, and only while the latch is 0.
- R5: In quasi-bidirectional mode with the boost idle, latch 0 asserts only `pad_drv_lo` and latch 1 asserts only `pad_pull_weak`.
- R6: In quasi-bidirectional mode, a write that changes the latch from 0 to 1 asserts `pad_drv_hi` together with `pad_pull_weak` for exactly the two clocks that follow the write edge.
- R7: In input-only mode, all three drive enables of the pin are 0.
- R8: A write to the level register changes the latch only for pins whose mode is not input-only. The latch of an input-only pin is kept and becomes visible when the pin later becomes an output.
- R9: A read with code 2 returns the filtered pad levels, not the latch.
- R10: A pad level is accepted after FILT_CLKS consecutive clock samples at the new level (default 2). A pulse shorter than that is rejected.
- R11: The configuration registers read back the last value written to them, and read code 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | DATA_W | Read data (combinational) |
| pad_in | input | DATA_W | Raw pad levels |
| pad_drv_hi | output | DATA_W | Per-pin strong high enable |
| pad_pull_weak | output | DATA_W | Per-pin weak pull-up enable |
| pad_drv_lo | output | DATA_W | Per-pin strong low enable |

## Verification
Some relations are checked by the assertions on every cycle:

- A write to the level register leaves an input-only pin's latch unchanged.
- A quasi-bidirectional latch rise always starts a strong pull-up.
- A push-pull pin follows the bit just written.
- The filter accepts a new level only after the two preceding samples agreed with it.
- The configuration registers never change without a write strobe.

Other behaviour only the bench scenarios can show. These are the exact two-clock length of the boost and its end, the rejection of a one-clock glitch, the field positions of each pin, and the reset value of the latch, which stays hidden until a pin is switched to an output.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;

    // Per-pin drive style; encoding is decoded by every pin controller.
    typedef enum logic [1:0] {
        MODE_QUASI = 2'b00,
        MODE_INPUT = 2'b01,
        MODE_PUSH  = 2'b10,
        MODE_OPEN  = 2'b11
    } pin_mode_e;

    // Register window selects shared by read and write paths.
    typedef enum logic [1:0] {
        SEL_CFG_LO = 2'd0,
        SEL_CFG_HI = 2'd1,
        SEL_LEVEL  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Quasi-bidirectional boost sequencer.
    typedef enum logic [1:0] {
        BST_IDLE   = 2'd0,
        BST_FIRST  = 2'd1,
        BST_SECOND = 2'd2
    } boost_state_e;

    // Glitch filter sequencer.
    typedef enum logic {
        F_STEADY  = 1'b0,
        F_CONFIRM = 1'b1
    } filt_state_e;

endpackage

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter
    import gpio_mode_pkg::*;
#(
    parameter int FILT_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_out
);
    localparam int CW = $clog2(FILT_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CLKS - 1);

    filt_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic filt_q, filt_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_STEADY;
            cnt_q   <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            filt_q  <= filt_d;
        end
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        filt_d  = filt_q;
        unique case (state_q)
            F_STEADY: begin
                if (raw_in != filt_q) begin
                    if (FILT_CLKS <= 1) begin
                        filt_d = raw_in;
                    end else begin
                        state_d = F_CONFIRM;
                        cnt_d   = CW'(1);
                    end
                end
            end
            F_CONFIRM: begin
                if (raw_in == filt_q) begin
                    state_d = F_STEADY;
                    cnt_d   = '0;
                end else if (cnt_q >= LAST) begin
                    state_d = F_STEADY;
                    cnt_d   = '0;
                    filt_d  = raw_in;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = F_STEADY;
                cnt_d   = '0;
            end
        endcase
    end

    assign level_out = filt_q;

    generate
        if (FILT_CLKS >= 2) begin : g_chk
            // R10
            filt_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (filt_q != $past(filt_q)) |-> ($past(raw_in) == filt_q && $past(raw_in, 2) == filt_q))
                else $error("filter accepted a level that was not held");
        end
    endgenerate

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_mode_pkg::*;
#(
    parameter logic LATCH_RST = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       lvl_wr,
    input  logic       lvl_bit,
    output logic       drv_hi,
    output logic       pull_weak,
    output logic       drv_lo
);
    boost_state_e state_q, state_d;
    logic latch_q, latch_d;
    logic take, rise;

    assign take = lvl_wr && (pin_mode_e'(mode) != MODE_INPUT);
    assign rise = take && lvl_bit && !latch_q;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BST_IDLE;
            latch_q <= LATCH_RST;
        end else begin
            state_q <= state_d;
            latch_q <= latch_d;
        end
    end

    // Next-state process
    always_comb begin
        latch_d = take ? lvl_bit : latch_q;
        state_d = state_q;
        unique case (state_q)
            BST_IDLE:   state_d = rise ? BST_FIRST : BST_IDLE;
            BST_FIRST:  state_d = rise ? BST_FIRST : BST_SECOND;
            BST_SECOND: state_d = rise ? BST_FIRST : BST_IDLE;
            default:    state_d = BST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        drv_hi    = 1'b0;
        pull_weak = 1'b0;
        drv_lo    = 1'b0;
        unique case (pin_mode_e'(mode))
            MODE_QUASI: begin
                drv_lo    = !latch_q;
                pull_weak = latch_q;
                drv_hi    = latch_q && (state_q != BST_IDLE);
            end
            MODE_INPUT: begin
                drv_lo = 1'b0;
            end
            MODE_PUSH: begin
                drv_hi = latch_q;
                drv_lo = !latch_q;
            end
            MODE_OPEN: begin
                drv_lo = !latch_q;
            end
            default: begin
                drv_lo = 1'b0;
            end
        endcase
    end

    // R8
    hold_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_wr && pin_mode_e'(mode) == MODE_INPUT) |=> $stable(latch_q))
        else $error("input-only latch changed on write");

    // R6
    boost_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(latch_q) && pin_mode_e'(mode) == MODE_QUASI) |-> drv_hi)
        else $error("quasi rise without strong pull-up");

    // R3
    push_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lvl_wr) && pin_mode_e'($past(mode)) == MODE_PUSH && pin_mode_e'(mode) == MODE_PUSH)
        |-> (drv_hi == $past(lvl_bit) && drv_lo == !$past(lvl_bit)))
        else $error("push-pull pin does not follow written bit");

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
    import gpio_mode_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int FILT_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_drv_hi,
    output logic [DATA_W-1:0] pad_pull_weak,
    output logic [DATA_W-1:0] pad_drv_lo
);
    localparam int HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] CFG_RST = {HALF{2'b01}};
    localparam logic [DATA_W-1:0] LVL_RST = {{(DATA_W - HALF){1'b0}}, {HALF{1'b1}}};

    logic [DATA_W-1:0] cfg_lo_q, cfg_hi_q;
    logic [DATA_W-1:0] pin_level;
    logic              lvl_wr;

    assign lvl_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_LEVEL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_lo_q <= CFG_RST;
            cfg_hi_q <= CFG_RST;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_sel) == SEL_CFG_LO) cfg_lo_q <= wr_data;
            if (reg_sel_e'(wr_sel) == SEL_CFG_HI) cfg_hi_q <= wr_data;
        end
    end

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_pin
            logic [1:0] pin_mode;
            if (i < HALF) begin : g_lo
                assign pin_mode = cfg_lo_q[2*i +: 2];
            end else begin : g_hi
                assign pin_mode = cfg_hi_q[2*(i-HALF) +: 2];
            end

            gpio_pin_ctrl #(
                .LATCH_RST (LVL_RST[i])
            ) u_ctrl (
                .clk       (clk),
                .rst_n     (rst_n),
                .mode      (pin_mode),
                .lvl_wr    (lvl_wr),
                .lvl_bit   (wr_data[i]),
                .drv_hi    (pad_drv_hi[i]),
                .pull_weak (pad_pull_weak[i]),
                .drv_lo    (pad_drv_lo[i])
            );

            gpio_glitch_filter #(
                .FILT_CLKS (FILT_CLKS)
            ) u_filt (
                .clk       (clk),
                .rst_n     (rst_n),
                .raw_in    (pad_in[i]),
                .level_out (pin_level[i])
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_sel))
            SEL_CFG_LO: rd_data = cfg_lo_q;
            SEL_CFG_HI: rd_data = cfg_hi_q;
            SEL_LEVEL:  rd_data = pin_level;
            SEL_NONE:   rd_data = '0;
            default:    rd_data = '0;
        endcase
    end

    // R11
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(cfg_lo_q) && $stable(cfg_hi_q)))
        else $error("configuration changed without a write");

endmodule

// File: tb/gpio_mode_port_tb.sv
`timescale 1ns/1ps
module gpio_mode_port_tb;
    localparam int W = 8;
    localparam int FILT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_drv_hi, pad_pull_weak, pad_drv_lo;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model state
    logic [W-1:0] m_cfg_lo, m_cfg_hi, m_lat, m_filt;
    logic [W-1:0] m_hist [FILT];
    int m_bst [W];

    always #2 clk = ~clk;

    gpio_mode_port #(.DATA_W(W), .FILT_CLKS(FILT)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .pad_in(pad_in),
        .pad_drv_hi(pad_drv_hi), .pad_pull_weak(pad_pull_weak), .pad_drv_lo(pad_drv_lo)
    );

    function automatic logic [1:0] pin_mode(int n);
        if (n < W/2) return m_cfg_lo[2*n +: 2];
        return m_cfg_hi[2*(n-W/2) +: 2];
    endfunction

    // returns {hi, weak, lo}
    function automatic logic [2:0] exp_drive(logic [1:0] m, logic l, logic b);
        case (m)
            2'b00: return {l & b, l, ~l};
            2'b01: return 3'b000;
            2'b10: return {l, 1'b0, ~l};
            default: return {1'b0, 1'b0, ~l};
        endcase
    endfunction

    function automatic logic [W-1:0] exp_read();
        case (rd_sel)
            2'd0: return m_cfg_lo;
            2'd1: return m_cfg_hi;
            2'd2: return m_filt;
            default: return '0;
        endcase
    endfunction

    task automatic model_reset();
        m_cfg_lo = 8'h55; m_cfg_hi = 8'h55; m_lat = 8'h0F; m_filt = '0;
        for (int k = 0; k < FILT; k++) m_hist[k] = '0;
        for (int n = 0; n < W; n++) m_bst[n] = 0;
    endtask

    task automatic model_edge();
        logic lvl;
        logic all_diff;
        lvl = wr_en && (wr_sel == 2'd2);
        for (int n = 0; n < W; n++) begin
            logic out_pin;
            out_pin = (pin_mode(n) != 2'b01);
            if (lvl && out_pin && wr_data[n] && !m_lat[n]) m_bst[n] = 2;
            else if (m_bst[n] > 0) m_bst[n] = m_bst[n] - 1;
        end
        for (int n = 0; n < W; n++)
            if (lvl && pin_mode(n) != 2'b01) m_lat[n] = wr_data[n];
        if (wr_en && wr_sel == 2'd0) m_cfg_lo = wr_data;
        if (wr_en && wr_sel == 2'd1) m_cfg_hi = wr_data;
        for (int k = FILT-1; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = pad_in;
        for (int n = 0; n < W; n++) begin
            all_diff = 1'b1;
            for (int k = 0; k < FILT; k++) if (m_hist[k][n] == m_filt[n]) all_diff = 1'b0;
            if (all_diff) m_filt[n] = ~m_filt[n];
        end
    endtask

    task automatic check_vec(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [W-1:0] e_hi, e_wk, e_lo;
        for (int n = 0; n < W; n++) begin
            logic [2:0] d;
            d = exp_drive(pin_mode(n), m_lat[n], m_bst[n] > 0);
            e_hi[n] = d[2]; e_wk[n] = d[1]; e_lo[n] = d[0];
        end
        check_vec(tag, "drv_hi", pad_drv_hi, e_hi);
        check_vec(tag, "pull_weak", pad_pull_weak, e_wk);
        check_vec(tag, "drv_lo", pad_drv_lo, e_lo);
        check_vec(tag, "rd_data", rd_data, exp_read());
    endtask

    task automatic step(string tag);
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic wr(logic [1:0] sel, logic [W-1:0] d, string tag);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step(tag);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd_sel = 2'd0; check_all("R1 reset cfg_lo");
        rd_sel = 2'd1; check_all("R1 R7 reset cfg_hi");

        wr(2'd0, 8'hAA, "R2 R3 push-pull low half shows latch reset");
        wr(2'd2, 8'h5A, "R8 level write");
        wr(2'd1, 8'hAA, "R8 R3 ignored write visible");
        wr(2'd0, 8'hFF, "R4 open-drain");
        wr(2'd0, 8'h00, "R5 quasi steady");
        wr(2'd2, 8'h0F, "R6 boost first clock");
        idle(1, "R6 boost second clock");
        idle(2, "R6 boost ended");
        wr(2'd1, 8'h55, "R7 input-only high half");
        wr(2'd2, 8'hF0, "R7 R8 write to input-only pins");
        wr(2'd1, 8'h1B, "R2 field positions high half");
        rd_sel = 2'd0; idle(1, "R11 read cfg low");
        rd_sel = 2'd1; idle(1, "R11 read cfg high");
        rd_sel = 2'd3; idle(1, "R11 unused select");
        rd_sel = 2'd2;
        pad_in = 8'h01; step("R10 glitch sampled once");
        pad_in = 8'h00; idle(3, "R10 R9 glitch rejected");
        pad_in = 8'h81; idle(3, "R10 R9 level accepted");
        wr(2'd0, 8'h00, "R5 quasi low half");
        wr(2'd2, 8'h00, "R5 quasi latch low");
        wr(2'd2, 8'h03, "R6 boost again");
        wr(2'd2, 8'h00, "R6 boost cut by latch low");
        idle(2, "R6 quiet");

        for (int i = 0; i < 600; i++) begin
            wr_en = (($urandom % 3) == 0);
            wr_sel = 2'($urandom % 4);
            wr_data = 8'($urandom);
            rd_sel = 2'($urandom % 4);
            if (($urandom % 4) == 0) pad_in = pad_in ^ (8'($urandom) & 8'($urandom));
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end
        wr_en = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule